// File: doc/BRIEF.md
# Packed Dual-Lane Floating-Point Adder

This block adds and subtracts single-precision floating-point numbers two at a time. Each 64-bit operand carries two 32-bit values, one in each half. A 2-bit operation code selects one of four forms. The first three are lane-wise add, A minus B and B minus A, where each half of the result depends only on the same half of both operands. The fourth is a horizontal accumulate, which adds the two halves of A together and the two halves of B together. All four forms run on the same pair of adder lanes. Only the routing of operands into the lanes changes.

The arithmetic is kept simple on purpose. There is one rounding mode. Results too large to represent clamp to the largest finite value, and results too small to represent become zero. The block never signals an exception and holds no status. The unit has two pipeline stages and accepts a new operation every cycle. A valid bit travels alongside the data, and there is no back-pressure. Infinity and NaN inputs are outside the supported range. Their results are not defined.

Top module: `pfadd_dual`

## Requirements
- R1: Bits 63:32 of each operand and of the result form the high lane, and bits 31:0 form the low lane. Both lanes use IEEE-754 single-precision format. Op code 2'b00 (add) writes A.low+B.low to the low lane and A.high+B.high to the high lane.
- R2: Op code 2'b01 (subtract) computes A minus B in each lane.
- R3: Op code 2'b10 (reverse subtract) computes B minus A in each lane.
- R4: Op code 2'b11 (accumulate) writes A.low+A.high to the result's low lane and B.low+B.high to the result's high lane.
- R5: Every result is rounded to nearest, with ties going to an even significand. This includes the case where rounding carries into the exponent.
- R6: A result whose magnitude is too large becomes the largest finite value of the same sign (0x7F7FFFFF or 0xFF7FFFFF). No result ever has an exponent field of all ones.
- R7: A nonzero result whose magnitude is below 2^-126 becomes +0 (0x00000000). A result equal to 2^-126 is kept (0x00800000). No result has a zero exponent field with a nonzero fraction.
- R8: An input with a zero exponent field is treated as a zero of its own sign.
- R9: An exact zero sum, for example from subtracting equal values, is +0 (0x00000000).
- R10: A result appears on out_data exactly two rising clock edges after its operands are sampled with in_valid high. At that point out_valid is high. out_valid copies in_valid delayed by two cycles. A new operation may start on every cycle.
- R11: While rst_n is low, out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| in_valid | input | 1 | Operands and op code are present this cycle |
| in_op | input | 2 | Operation select: 00 add, 01 A-B, 10 B-A, 11 accumulate |
| in_a | input | 64 | Operand A, two packed single-precision values |
| in_b | input | 64 | Operand B, two packed single-precision values |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | 64 | Two packed single-precision results |

## Verification
Operands enter on the rising edge at which in_valid is sampled high. The first register stage stores the aligned operands, and the second stores the rounded result. Both lanes of the result can therefore be read just after the second rising edge that follows. Each directed scenario drives its operands at a falling edge and then waits for two falling edges before it compares out_data and out_valid. This way every sample falls between the second and third rising edges. A streaming scenario issues operations on consecutive cycles with one gap between them. At each falling edge it checks the result of the operation issued two falling edges earlier. This confirms one operation per cycle and confirms that the valid bit follows the data, bubble included.

// File: rtl/pfadd_pkg.sv
package pfadd_pkg;

  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;         // significand with hidden bit
  localparam int EXT_W   = SIG_W + 3;          // plus guard, round, sticky
  localparam int LANES   = 2;
  localparam int PACK_W  = FP_W * LANES;
  localparam int SUM_W   = EXT_W + 1;          // room for carry out
  localparam int LZ_W    = $clog2(SUM_W + 1);
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_HACC = 2'b11
  } pf_op_e;

  // One lane after operand alignment: the first pipeline stage contents.
  typedef struct packed {
    logic               sign_big;
    logic               eff_sub;
    logic [EXP_W-1:0]   exp_big;
    logic [EXT_W-1:0]   mag_big;
    logic [EXT_W-1:0]   mag_small;
  } align_t;

endpackage

// File: rtl/pfadd_route.sv
module pfadd_route
  import pfadd_pkg::*;
(
  input  logic [1:0]                  op_i,
  input  logic [PACK_W-1:0]           a_i,
  input  logic [PACK_W-1:0]           b_i,
  output logic [LANES-1:0][FP_W-1:0]  x_o,
  output logic [LANES-1:0][FP_W-1:0]  y_o
);

  logic [LANES-1:0][FP_W-1:0] a_l, b_l;
  pf_op_e op;

  assign a_l = a_i;
  assign b_l = b_i;
  assign op  = pf_op_e'(op_i);

  // Subtraction is an addition with the second addend's sign flipped.
  always_comb begin
    x_o = a_l;
    y_o = b_l;
    unique case (op)
      OP_ADD: begin
        x_o = a_l;
        y_o = b_l;
      end
      OP_SUB: begin
        x_o = a_l;
        for (int i = 0; i < LANES; i++) y_o[i] = {~b_l[i][FP_W-1], b_l[i][FP_W-2:0]};
      end
      OP_RSUB: begin
        x_o = b_l;
        for (int i = 0; i < LANES; i++) y_o[i] = {~a_l[i][FP_W-1], a_l[i][FP_W-2:0]};
      end
      OP_HACC: begin
        x_o[0] = a_l[0];
        y_o[0] = a_l[1];
        x_o[1] = b_l[0];
        y_o[1] = b_l[1];
      end
      default: begin
        x_o = a_l;
        y_o = b_l;
      end
    endcase
  end

endmodule

// File: rtl/pfadd_align.sv
module pfadd_align
  import pfadd_pkg::*;
(
  input  logic [FP_W-1:0] x_i,
  input  logic [FP_W-1:0] y_i,
  output align_t          al_o
);

  localparam int WIDE_W = 2 * SIG_W;

  logic             sx, sy, sb, ss;
  logic [EXP_W-1:0] ex, ey, eb, es, diff;
  logic [SIG_W-1:0] mx, my, mb, ms;
  logic             x_big;
  logic [WIDE_W-1:0] wide, shifted;
  logic [EXT_W-2:0] top;
  logic             sticky;

  always_comb begin
    sx = x_i[FP_W-1];
    sy = y_i[FP_W-1];
    ex = x_i[FP_W-2:FRAC_W];
    ey = y_i[FP_W-2:FRAC_W];
    // zero exponent field: treat as signed zero
    mx = (ex == '0) ? '0 : {1'b1, x_i[FRAC_W-1:0]};
    my = (ey == '0) ? '0 : {1'b1, y_i[FRAC_W-1:0]};

    x_big = {ex, mx} >= {ey, my};
    sb = x_big ? sx : sy;
    ss = x_big ? sy : sx;
    eb = x_big ? ex : ey;
    es = x_big ? ey : ex;
    mb = x_big ? mx : my;
    ms = x_big ? my : mx;
    diff = eb - es;

    wide    = {ms, {SIG_W{1'b0}}};
    shifted = wide >> diff;
    if (diff >= EXP_W'(WIDE_W)) begin
      top    = '0;
      sticky = |ms;
    end else begin
      top    = shifted[WIDE_W-1 -: (EXT_W-1)];
      sticky = |shifted[WIDE_W-EXT_W:0];
    end

    al_o.sign_big  = sb;
    al_o.eff_sub   = sb ^ ss;
    al_o.exp_big   = eb;
    al_o.mag_big   = {mb, 3'b000};
    al_o.mag_small = {top, sticky};
  end

endmodule

// File: rtl/pfadd_finish.sv
module pfadd_finish
  import pfadd_pkg::*;
(
  input  align_t          al_i,
  output logic [FP_W-1:0] res_o
);

  function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n    = '0;
    seen = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!seen && !v[i]) n = n + 1'b1;
      else                seen = 1'b1;
    end
    return n;
  endfunction

  logic [SUM_W-1:0]  sum;
  logic [EXT_W-1:0]  norm;
  logic [LZ_W-1:0]   lz;
  logic signed [EXP_W+2:0] e_norm, e_fin;
  logic [SIG_W-1:0]  keep;
  logic              rnd_up;
  logic [SIG_W:0]    rnd;
  logic [FRAC_W-1:0] frac;

  always_comb begin
    if (al_i.eff_sub) sum = {1'b0, al_i.mag_big} - {1'b0, al_i.mag_small};
    else              sum = {1'b0, al_i.mag_big} + {1'b0, al_i.mag_small};

    lz = '0;
    if (sum[SUM_W-1]) begin
      norm   = {sum[SUM_W-1:2], sum[1] | sum[0]};
      e_norm = $signed({3'b000, al_i.exp_big}) + 11'sd1;
    end else begin
      lz     = lead_zeros(sum[EXT_W-1:0]);
      norm   = sum[EXT_W-1:0] << lz;
      e_norm = $signed({3'b000, al_i.exp_big}) - $signed({{(EXP_W+3-LZ_W){1'b0}}, lz});
    end

    keep   = norm[EXT_W-1:3];
    rnd_up = norm[2] & (norm[1] | norm[0] | keep[0]);
    rnd    = {1'b0, keep} + {{SIG_W{1'b0}}, rnd_up};
    if (rnd[SIG_W]) begin
      frac  = rnd[SIG_W-1:1];
      e_fin = e_norm + 11'sd1;
    end else begin
      frac  = rnd[FRAC_W-1:0];
      e_fin = e_norm;
    end

    if (sum == '0) begin
      res_o = '0;
    end else if (e_fin >= $signed(11'(EXP_MAX))) begin
      res_o = {al_i.sign_big, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
    end else if (e_fin <= 11'sd0) begin
      res_o = '0;
    end else begin
      res_o = {al_i.sign_big, e_fin[EXP_W-1:0], frac};
    end
  end

endmodule

// File: rtl/pfadd_dual.sv
module pfadd_dual
  import pfadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [63:0]       in_a,
  input  logic [63:0]       in_b,
  output logic              out_valid,
  output logic [63:0]       out_data
);

  logic [LANES-1:0][FP_W-1:0] lane_x, lane_y, lane_res;
  align_t [LANES-1:0]         st1_d, st1_q;
  logic                       st1_vld_d, st1_vld_q;
  logic                       out_vld_d;
  logic [PACK_W-1:0]          out_data_d;

  pfadd_route u_route (
    .op_i (in_op),
    .a_i  (in_a),
    .b_i  (in_b),
    .x_o  (lane_x),
    .y_o  (lane_y)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pfadd_align u_align (
      .x_i  (lane_x[g]),
      .y_i  (lane_y[g]),
      .al_o (st1_d[g])
    );
    pfadd_finish u_finish (
      .al_i  (st1_q[g]),
      .res_o (lane_res[g])
    );
  end

  // next-state logic
  always_comb begin
    st1_vld_d  = in_valid;
    out_vld_d  = st1_vld_q;
    out_data_d = lane_res;
  end

  // valid bits: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_vld_q <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      st1_vld_q <= st1_vld_d;
      out_valid <= out_vld_d;
    end
  end

  // data: no reset, loaded only when a valid operation passes
  always_ff @(posedge clk) begin
    if (st1_vld_d) st1_q    <= st1_d;
    if (out_vld_d) out_data <= out_data_d;
  end

endmodule

// File: rtl/pfadd_dual_checker.sv
module pfadd_dual_checker
  import pfadd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [PACK_W-1:0] out_data
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_known_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_data));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[62:55] != 8'hFF && out_data[30:23] != 8'hFF));

  assert_no_tiny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data[62:55] != 8'h00 || out_data[63:32] == 32'h0) &&
                   (out_data[30:23] != 8'h00 || out_data[31:0]  == 32'h0)));

  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R11: assert (!out_valid);
  end

endmodule

bind pfadd_dual pfadd_dual_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/pfadd_dual_bench.sv
`timescale 1ns/1ps
module pfadd_dual_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;

  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, RSUB = 2'b10, HACC = 2'b11;

  always #2 clk = ~clk;

  pfadd_dual u_pfadd_dual (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample two falling edges later
  task automatic run_one(input string req, input logic [1:0] op,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check1(req, out_valid, 1'b1);
    check64(req, out_data, exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check1("R11", out_valid, 1'b0);
  endtask

  task automatic test_add();   // R1
    run_one("R1", ADD, {32'h40000000, 32'h3F800000}, {32'h40400000, 32'h3F000000},
            {32'h40A00000, 32'h3FC00000});
  endtask

  task automatic test_sub();   // R2
    run_one("R2", SUB, {32'h40800000, 32'h3F800000}, {32'h3F800000, 32'h40400000},
            {32'h40400000, 32'hC0000000});
  endtask

  task automatic test_rsub();  // R3
    run_one("R3", RSUB, {32'h40800000, 32'h3F800000}, {32'h3F800000, 32'h40400000},
            {32'hC0400000, 32'h40000000});
  endtask

  task automatic test_acc();   // R4
    run_one("R4", HACC, {32'h40000000, 32'h3F800000}, {32'h40400000, 32'h40800000},
            {32'h40E00000, 32'h40400000});
  endtask

  task automatic test_zero();  // R9
    run_one("R9", SUB, {32'h40A00000, 32'hBF800000}, {32'h40A00000, 32'hBF800000},
            64'h0);
  endtask

  task automatic test_round(); // R5
    run_one("R5", ADD, {32'h3F800001, 32'h3F800000}, {32'h33800000, 32'h33C00000},
            {32'h3F800002, 32'h3F800001});
    run_one("R5", ADD, {32'h3F800000, 32'h3F800000}, {32'h33000000, 32'h33800000},
            {32'h3F800000, 32'h3F800000});
    run_one("R5", ADD, {32'h3F800000, 32'h3FFFFFFF}, {32'h00000000, 32'h33800000},
            {32'h3F800000, 32'h40000000});
  endtask

  task automatic test_overflow(); // R6
    run_one("R6", ADD, {32'hFF7FFFFF, 32'h7F7FFFFF}, {32'hFF7FFFFF, 32'h7F7FFFFF},
            {32'hFF7FFFFF, 32'h7F7FFFFF});
  endtask

  task automatic test_underflow(); // R7
    run_one("R7", SUB, {32'h01000000, 32'h00C00000}, {32'h00800000, 32'h00800000},
            {32'h00800000, 32'h00000000});
  endtask

  task automatic test_denorm(); // R8
    run_one("R8", ADD, {32'h80400000, 32'h00400000}, {32'h3F800000, 32'h00400000},
            {32'h3F800000, 32'h00000000});
  endtask

  task automatic test_stream(); // R10
    logic [1:0]  so [4];
    logic [63:0] sa [4];
    logic [63:0] sb [4];
    logic [63:0] se [4];
    logic        sv [4];
    so[0] = ADD;  sa[0] = {32'h40000000, 32'h3F800000}; sb[0] = {32'h40400000, 32'h3F000000};
    se[0] = {32'h40A00000, 32'h3FC00000}; sv[0] = 1'b1;
    so[1] = HACC; sa[1] = {32'h40000000, 32'h3F800000}; sb[1] = {32'h40400000, 32'h40800000};
    se[1] = {32'h40E00000, 32'h40400000}; sv[1] = 1'b1;
    so[2] = SUB;  sa[2] = '0; sb[2] = '0; se[2] = '0; sv[2] = 1'b0;
    so[3] = RSUB; sa[3] = {32'h40800000, 32'h3F800000}; sb[3] = {32'h3F800000, 32'h40400000};
    se[3] = {32'hC0400000, 32'h40000000}; sv[3] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check1("R10", out_valid, sv[i-2]);
        if (sv[i-2]) check64("R10", out_data, se[i-2]);
      end
      if (i < 4) begin
        in_valid = sv[i]; in_op = so[i]; in_a = sa[i]; in_b = sb[i];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_add();
    test_sub();
    test_rsub();
    test_acc();
    test_zero();
    test_round();
    test_overflow();
    test_underflow();
    test_denorm();
    test_stream();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule